// File: doc/BRIEF.md
# Step Attenuator Control Interface

This block is the digital front end of a 6-bit step attenuator. It delivers an attenuation code in which each LSB is worth 0.5 dB, so the code range 0 to 63 spans 0 dB to 31.5 dB. The bit weights, from the MSB down, are 16, 8, 4, 2, 1 and 0.5 dB. A mode pin selects one of two ways of setting the code. When it is low, the code comes from six parallel pins. When it is high, the code comes from a serial shift register driven by a data pin and a clock pin.

Both paths feed a single latch that is transparent while the latch-enable pin is high and holds its value while that pin is low. In parallel mode the latch-enable pin gives two uses. Held high, the code follows the pins directly. Pulsed high and then low, it captures the pins at that moment.

When reset is released, the code takes an initial value chosen from the mode pin, the latch-enable level and two selection bits. That value holds until the first real update replaces it. The serial clock, serial data and latch-enable inputs are synchronized into the system clock domain, so the system clock must run at least four times faster than the serial clock.

Top module: `step_atten_ctrl`

## Requirements
- R1: When reset is released with `ser_mode` high, `atten_code` equals `par_word` as sampled during reset.
- R2: When reset is released with `ser_mode` low and `latch_en` low, `atten_code` is set from `pwr_sel` as follows. The value 00 gives code 0. The value 10 (bit 1 set) gives code 16 (8 dB). The value 01 (bit 0 set) gives code 32 (16 dB). The value 11 gives code 63 (31.5 dB).
- R3: When reset is released with `ser_mode` low and `latch_en` high, `pwr_sel` has no effect and `atten_code` equals `par_word`.
- R4: Each rising edge of `ser_clk` shifts `ser_data` into the LSB end of the serial register, whatever the level of `latch_en`. After six shifts the first bit sent sits in the MSB, the 16 dB position.
- R5: While `latch_en` is low, `atten_code` does not change, even if serial shifts occur or `par_word` changes.
- R6: In serial mode, once a rising edge has been seen on `latch_en`, the output follows the shift register bit by bit for as long as `latch_en` stays high.
- R7: In latched parallel mode, a high-then-low pulse on `latch_en` captures `par_word`. Changes to `par_word` after the pulse have no effect.
- R8: In direct parallel mode, with `latch_en` held high, `atten_code` follows `par_word` one clock later.
- R9: A word loaded by reset in serial mode stays in place, even while `latch_en` is high and shifts occur, until a fresh rising edge on `latch_en` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset; its release stands for power-up |
| ser_mode | input | 1 | 1 selects the serial path, 0 selects the parallel path |
| ser_data | input | 1 | Serial data, MSB first |
| ser_clk | input | 1 | Serial clock; data is shifted on its rising edge |
| latch_en | input | 1 | Latch enable: high makes the latch transparent, low holds the code |
| par_word | input | WORD_W | Parallel attenuation code, and the source of the power-up word |
| pwr_sel | input | 2 | Selects the power-up word in parallel mode with latch enable low |
| atten_code | output | WORD_W | Attenuation code, 0.5 dB per LSB |

## Verification
The bench builds the block with WORD_W = 6 and SYNC_STAGES = 3. The deeper synchronizer makes every latch update pass through a longer pipeline, so the bench's generous settling waits are put to work. The 6-bit word keeps all four power-up codes and the full range of random codes within reach. Serial clocking runs at one eighth of the system clock, above the minimum ratio, and random serial, latched-parallel and direct-parallel traffic is mixed with directed cases for each power-up selection.

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl #(
  parameter int WORD_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_mode,
  input  logic              ser_data,
  input  logic              ser_clk,
  input  logic              latch_en,
  input  logic [WORD_W-1:0] par_word,
  input  logic [1:0]        pwr_sel,
  output logic [WORD_W-1:0] atten_code
);

  localparam logic [WORD_W-1:0] CODE_MID = WORD_W'(1) << (WORD_W - 2);
  localparam logic [WORD_W-1:0] CODE_TOP = WORD_W'(1) << (WORD_W - 1);
  localparam logic [WORD_W-1:0] CODE_ALL = {WORD_W{1'b1}};

  logic [SYNC_STAGES-1:0] sck_q, sdt_q, le_q;
  logic                   sck_d, le_d, armed;
  logic [WORD_W-1:0]      shreg, boot_word, load_word;
  logic                   sck_s, sdt_s, le_s, sck_rise, le_rise, transparent;

  assign sck_s    = sck_q[SYNC_STAGES-1];
  assign sdt_s    = sdt_q[SYNC_STAGES-1];
  assign le_s     = le_q[SYNC_STAGES-1];
  assign sck_rise = sck_s & ~sck_d;
  assign le_rise  = le_s & ~le_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= {SYNC_STAGES{ser_clk}};
      le_q  <= {SYNC_STAGES{latch_en}};
      sdt_q <= '0;
      sck_d <= ser_clk;
      le_d  <= latch_en;
    end else begin
      sck_q <= {sck_q[SYNC_STAGES-2:0], ser_clk};
      le_q  <= {le_q[SYNC_STAGES-2:0], latch_en};
      sdt_q <= {sdt_q[SYNC_STAGES-2:0], ser_data};
      sck_d <= sck_s;
      le_d  <= le_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        shreg <= '0;
    else if (sck_rise) shreg <= {shreg[WORD_W-2:0], sdt_s};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       armed <= 1'b0;
    else if (le_rise) armed <= 1'b1;
  end

  always_comb begin
    if (ser_mode || latch_en) boot_word = par_word;
    else begin
      case (pwr_sel)
        2'b00:   boot_word = '0;
        2'b10:   boot_word = CODE_MID;
        2'b01:   boot_word = CODE_TOP;
        default: boot_word = CODE_ALL;
      endcase
    end
  end

  assign transparent = le_s & (armed | ~ser_mode);
  assign load_word   = ser_mode ? shreg : par_word;

  always_ff @(posedge clk) begin
    if (!rst_n)           atten_code <= boot_word;
    else if (transparent) atten_code <= load_word;
  end

  p_shift_only_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_rise |=> $stable(shreg));

  p_hold_while_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !le_s |=> $stable(atten_code));

  p_serial_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_mode && le_s && armed) |=> atten_code == $past(shreg));

  p_direct_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_mode && le_s) |=> atten_code == $past(par_word));

  p_boot_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_mode && !armed) |=> $stable(atten_code));

endmodule

// File: tb/test_step_atten_ctrl.sv
module test_step_atten_ctrl;
  localparam int W = 6;
  logic clk = 0, rst_n = 0, ser_mode = 0, ser_data = 0, ser_clk = 0, latch_en = 0;
  logic [W-1:0] par_word = '0;
  logic [1:0]   pwr_sel = '0;
  logic [W-1:0] atten_code;
  int checks = 0, fails = 0;
  bit done = 0;

  step_atten_ctrl #(.WORD_W(W), .SYNC_STAGES(3)) i_step_atten_ctrl (
    .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .ser_data(ser_data),
    .ser_clk(ser_clk), .latch_en(latch_en), .par_word(par_word),
    .pwr_sel(pwr_sel), .atten_code(atten_code));

  always #5 clk = ~clk;

  function automatic logic [W-1:0] boot_exp(logic m, logic le, logic [W-1:0] p, logic [1:0] s);
    if (m || le) return p;
    case (s)
      2'b00: return 6'd0;
      2'b10: return 6'd16;
      2'b01: return 6'd32;
      default: return 6'd63;
    endcase
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [W-1:0] exp);
    checks++;
    if (atten_code !== exp) begin
      fails++;
      $display("FAIL %s: atten_code=%0d expected=%0d", tag, atten_code, exp);
    end
  endtask

  task automatic do_reset(logic m, logic le, logic [W-1:0] p, logic [1:0] s);
    @(negedge clk);
    ser_mode = m; latch_en = le; par_word = p; pwr_sel = s; ser_clk = 0; ser_data = 0;
    rst_n = 0;
    wait_clk(3);
    rst_n = 1;
    wait_clk(2);
  endtask

  task automatic send_bit(logic b);
    ser_data = b;
    wait_clk(4);
    ser_clk = 1;
    wait_clk(4);
    ser_clk = 0;
  endtask

  task automatic send_word(logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) send_bit(w[i]);
    wait_clk(8);
  endtask

  task automatic le_pulse();
    latch_en = 1;
    wait_clk(8);
    latch_en = 0;
    wait_clk(8);
  endtask

  initial begin
    logic [W-1:0] w, prev, p;
    void'($urandom(32'h5eed_1234));
    wait_clk(2);

    // R1: power-up in serial mode takes par_word
    do_reset(1, 0, 6'd45, 2'b11);
    check("R1", 6'd45);

    // R2: power-up selection table (parallel, latch enable low)
    for (int s = 0; s < 4; s++) begin
      do_reset(0, 0, 6'd9, 2'(s));
      check("R2", boot_exp(0, 0, 6'd9, 2'(s)));
    end
    // R5/R7: parallel pins move while latch enable low: no effect
    par_word = 6'd21;
    wait_clk(10);
    check("R5", 6'd63);

    // R3: parallel, latch enable high: selection ignored
    do_reset(0, 1, 6'd5, 2'b11);
    check("R3", 6'd5);

    // R4/R5: serial traffic with latch closed, then pulse
    do_reset(1, 0, 6'd0, 2'b00);
    prev = 6'd0;
    for (int k = 0; k < 20; k++) begin
      w = W'($urandom);
      send_word(w);
      check("R5", prev);
      le_pulse();
      check("R4", w);
      prev = w;
    end
    send_word(6'b100000);
    le_pulse();
    check("R4", 6'd32);
    send_word(6'b000001);
    le_pulse();
    check("R4", 6'd1);

    // R6: transparent serial, output follows each shift
    latch_en = 1;
    wait_clk(8);
    send_bit(1); send_bit(0); send_bit(1);
    wait_clk(8);
    check("R6", {prev[2:0] == 3'b0 ? 3'b0 : 3'b0, 3'b101} | 6'(6'd1 << 3));
    latch_en = 0;
    wait_clk(8);

    // R9: serial power-up with latch enable high keeps the boot word
    do_reset(1, 1, 6'd38, 2'b00);
    send_word(6'd7);
    check("R9", 6'd38);
    latch_en = 0;
    wait_clk(8);
    latch_en = 1;
    wait_clk(8);
    check("R9", 6'd7);
    latch_en = 0;
    wait_clk(8);

    // R7: latched parallel, random words
    do_reset(0, 0, 6'd0, 2'b00);
    for (int k = 0; k < 20; k++) begin
      p = W'($urandom);
      par_word = p;
      wait_clk(3);
      le_pulse();
      par_word = ~p;
      wait_clk(8);
      check("R7", p);
    end

    // R8: direct parallel, output follows pins
    do_reset(0, 1, 6'd0, 2'b00);
    for (int k = 0; k < 20; k++) begin
      p = W'($urandom);
      par_word = p;
      wait_clk(2);
      check("R8", p);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule